// File: doc/BRIEF.md
# BCD Calendar Register Bank

This block keeps time of day and calendar date in a bank of 4-bit BCD counters. The counters run from tenths of seconds up to tens of years. A host reads and writes them one nibble at a time over a small asynchronous bus: a 4-bit address, 4-bit write data, 4-bit read data, and active-low chip select, read and write strobes. The host supplies no clock on this bus. The block synchronizes the strobes to its own clock. It commits a write when the combined write strobe ends, and it captures read data when the combined read strobe begins.

A 10 Hz update pulse comes from outside the block. On each pulse all counters advance together, in one clock cycle, through a cascade of carries. The cascade covers second and minute rollover, hours in 12-hour or 24-hour form, month lengths, and a four-year leap cycle. The control register at address 0 holds two bits. The stop bit halts the clock and zeroes the tenths counter, so a restart resumes on a whole second. The sticky data-changed bit lets software detect an update that happened during a burst of reads.

Top module: `rtc_regbank`

## Requirements
- R1: A write takes effect only when the combined write strobe (chip select and write both low) ends. It commits exactly once per strobe, using the address and data held while the strobe was active. These must stay valid for 2 clock cycles after the strobe ends.
- R2: Address map:
  - 0: control
  - 1: tenths of seconds
  - 2 / 3: seconds units / tens
  - 4 / 5: minutes units / tens
  - 6 / 7: hours units / tens
  - 8 / 9: day units / tens
  - 10 / 11: month units / tens
  - 12 / 13: year units / tens
  - 14: day of week
  - 15: mode

  Any address can be read at any time. A read captures the addressed nibble at the start of the read strobe and holds it on rdata_o until the next read.
- R3: Narrow fields use only their low bits: seconds tens 3 bits, minutes tens 3 bits, hours tens 2 bits, day tens 2 bits, month tens 1 bit, day of week 3 bits. Their upper bits read as 0, and writes to those bits are discarded.
- R4: In the control register, bit 2 is stop and bit 3 is data-changed; bits 1:0 read 0, and a write to bit 3 is ignored. Writing 1 to bit 2 clears the tenths counter. While stopped, update pulses change no counter and do not set data-changed. Reset leaves the clock stopped.
- R5: After 0 is written to the stop bit, counting starts from a whole second: ten update pulses advance the seconds by exactly one.
- R6: Each update pulse advances tenths (9 to 0). The carry ripples through seconds and minutes (59 to 00) within the same cycle.
- R7: Each update pulse while running sets data-changed. A read of address 0 clears it. If an update pulse arrives in the same cycle as that read, the flag stays set.
- R8: With mode bit 0 = 1 (24-hour), hours count 00 to 23, and 23 to 00 advances the day.
- R9: With mode bit 0 = 0 (12-hour), hours count 12, 1, ..., 11. Mode bit 1 (PM) toggles on 11 to 12, and the day advances only when that step happens with PM set.
- R10: Days roll to 01 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other long months. The month then advances, and December rolls to January while the year advances.
- R11: Mode bits 3:2 form a leap counter, where 0 marks a leap year. In a leap year February ends on 29, otherwise on 28. Every year advance increments the counter modulo 4, and year 99 rolls to 00.
- R12: Day of week counts 1 to 7 and advances with every day rollover, 7 wrapping to 1.
- R13: Reset values:
  - all time fields 0, except day 01, month 01 and day of week 1
  - mode 0b0001 (24-hour, AM, leap year)
  - control 0b0100

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 10 Hz update pulse |
| cs_ni | input | 1 | Active-low chip select |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data nibble |
| rdata_o | output | 4 | Read data nibble |

## Verification
The bench drives the full carry chain from 23:59:59.9 on December 31 of year 99. A broken cascade would leave some field unrolled, skip the leap counter, or miss the day-of-week wrap. February is tested both with and without the leap flag, and a 30-day month is tested too. A wrong month table would land on an impossible day or on the wrong next month. In 12-hour form the bench walks 11 to 12 to 1 in both halves of the day. A design that flips PM at the wrong step, or advances the day at noon, shows up in the day and mode reads. An update pulse is placed in exactly the cycle of a control read, to catch a clear that wins over the set. A stop or restart that fails to zero the tenths would show the seconds stepping early.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_TENTHS = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_SEC_U  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_SEC_T  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_MIN_U  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_MIN_T  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_HR_U   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_HR_T   = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_DAY_U  = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_DAY_T  = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_MON_U  = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_MON_T  = 4'd11;
  localparam logic [ADDR_W-1:0] ADR_YR_U   = 4'd12;
  localparam logic [ADDR_W-1:0] ADR_YR_T   = 4'd13;
  localparam logic [ADDR_W-1:0] ADR_DOW    = 4'd14;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd15;

  typedef struct packed {
    logic [3:0] tenths;
    logic [3:0] sec_u;
    logic [2:0] sec_t;
    logic [3:0] min_u;
    logic [2:0] min_t;
    logic [3:0] hr_u;
    logic [1:0] hr_t;
    logic [3:0] day_u;
    logic [1:0] day_t;
    logic [3:0] mon_u;
    logic       mon_t;
    logic [3:0] yr_u;
    logic [3:0] yr_t;
    logic [2:0] dow;
    logic       h24;
    logic       pm;
    logic [1:0] leap;
  } rtc_time_t;

  // last day of month as BCD {tens[1:0], units[3:0]}
  function automatic logic [5:0] last_day(logic mt, logic [3:0] mu, logic leap_yr);
    logic [4:0] m;
    m = mt ? (5'd10 + {1'b0, mu}) : {1'b0, mu};
    case (m)
      5'd2:                      return leap_yr ? {2'd2, 4'd9} : {2'd2, 4'd8};
      5'd4, 5'd6, 5'd9, 5'd11:   return {2'd3, 4'd0};
      default:                   return {2'd3, 4'd1};
    endcase
  endfunction
endpackage

// File: rtl/rtc_bus_if.sv
module rtc_bus_if #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int NIB_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic              rd_start_o,
  output logic              wr_commit_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [NIB_W-1:0]  wr_data_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ws_sync, rs_sync;
  logic ws_prev, rs_prev;
  logic ws_s, rs_s;

  assign ws_s = ws_sync[LAST];
  assign rs_s = rs_sync[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_sync <= '0;
      rs_sync <= '0;
      ws_prev <= 1'b0;
      rs_prev <= 1'b0;
    end else begin
      ws_sync <= {ws_sync[SYNC_STAGES-2:0], ~cs_ni & ~wr_ni};
      rs_sync <= {rs_sync[SYNC_STAGES-2:0], ~cs_ni & ~rd_ni};
      ws_prev <= ws_s;
      rs_prev <= rs_s;
    end
  end

  // hold address/data seen while strobe active; used at trailing edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (ws_s) begin
      wr_addr_o <= addr_i;
      wr_data_o <= wdata_i;
    end
  end

  assign wr_commit_o = ws_prev & ~ws_s;
  assign rd_start_o  = rs_s & ~rs_prev;

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o); // R1
  AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_o |=> !rd_start_o); // R2
endmodule

// File: rtl/rtc_bcd_pair.sv
module rtc_bcd_pair #(
  parameter int TENS_W   = 3,
  parameter int TENS_MAX = 5,
  parameter int NIB_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_units_i,
  input  logic              wr_tens_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [NIB_W-1:0]  units_o,
  output logic [TENS_W-1:0] tens_o,
  output logic              carry_o
);
  localparam logic [NIB_W-1:0]  UNITS_TOP = NIB_W'(9);
  localparam logic [TENS_W-1:0] TENS_TOP  = TENS_W'(TENS_MAX);

  logic units_end;
  assign units_end = (units_o == UNITS_TOP);
  assign carry_o   = inc_i && units_end && (tens_o == TENS_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      units_o <= '0;
      tens_o  <= '0;
    end else begin
      if (wr_units_i)   units_o <= wdata_i;
      else if (inc_i)   units_o <= units_end ? '0 : units_o + 1'b1;
      if (wr_tens_i)    tens_o  <= wdata_i[TENS_W-1:0];
      else if (inc_i && units_end)
                        tens_o  <= (tens_o == TENS_TOP) ? '0 : tens_o + 1'b1;
    end
  end

  AST_PAIR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o && !wr_units_i && !wr_tens_i) |=> (units_o == '0 && tens_o == '0)); // R6
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_tenths_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NIB_W-1:0]  wr_data_i,
  output rtc_time_t         time_o
);
  localparam int N_PAIR = 2;

  logic [3:0] tenths_q, hr_u_q, day_u_q, mon_u_q, yr_u_q, yr_t_q;
  logic [1:0] hr_t_q, day_t_q, leap_q;
  logic       mon_t_q, h24_q, pm_q;
  logic [2:0] dow_q;

  logic tick_eff, tenths_carry;
  logic [N_PAIR-1:0] pair_inc, pair_c;
  logic [3:0] pair_u [N_PAIR];
  logic [2:0] pair_t [N_PAIR];

  function automatic logic hit(logic en, logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] r);
    return en && (a == r);
  endfunction

  assign tick_eff     = tick_i && !clr_tenths_i;
  assign tenths_carry = tick_eff && (tenths_q == 4'd9);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 tenths_q <= '0;
    else if (clr_tenths_i)                       tenths_q <= '0;
    else if (hit(wr_en_i, wr_addr_i, ADR_TENTHS)) tenths_q <= wr_data_i;
    else if (tick_eff)                           tenths_q <= tenths_carry ? 4'd0 : tenths_q + 4'd1;
  end

  // seconds then minutes
  assign pair_inc[0] = tenths_carry;
  assign pair_inc[1] = pair_c[0];

  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    localparam logic [ADDR_W-1:0] BASE = ADR_SEC_U + ADDR_W'(2 * g);
    rtc_bcd_pair #(.TENS_W(3), .TENS_MAX(5), .NIB_W(NIB_W)) u_pair (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (pair_inc[g]),
      .wr_units_i (hit(wr_en_i, wr_addr_i, BASE)),
      .wr_tens_i  (hit(wr_en_i, wr_addr_i, BASE + 4'd1)),
      .wdata_i    (wr_data_i),
      .units_o    (pair_u[g]),
      .tens_o     (pair_t[g]),
      .carry_o    (pair_c[g])
    );
  end

  // hours
  logic hr_inc, pm_flip, day_wrap, day_inc;
  logic [3:0] hr_nu;
  logic [1:0] hr_nt;
  assign hr_inc = pair_c[1];

  always_comb begin
    hr_nu    = hr_u_q + 4'd1;
    hr_nt    = hr_t_q;
    pm_flip  = 1'b0;
    day_wrap = 1'b0;
    if (h24_q) begin
      if (hr_t_q == 2'd2 && hr_u_q == 4'd3) begin
        hr_nu = 4'd0; hr_nt = 2'd0; day_wrap = 1'b1;
      end else if (hr_u_q == 4'd9) begin
        hr_nu = 4'd0; hr_nt = hr_t_q + 2'd1;
      end
    end else begin
      if (hr_t_q == 2'd1 && hr_u_q == 4'd1) begin
        hr_nu = 4'd2; pm_flip = 1'b1; day_wrap = pm_q;
      end else if (hr_t_q == 2'd1 && hr_u_q == 4'd2) begin
        hr_nu = 4'd1; hr_nt = 2'd0;
      end else if (hr_u_q == 4'd9) begin
        hr_nu = 4'd0; hr_nt = 2'd1;
      end
    end
  end

  assign day_inc = hr_inc && day_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hr_u_q <= '0;
      hr_t_q <= '0;
    end else begin
      if (hit(wr_en_i, wr_addr_i, ADR_HR_U)) hr_u_q <= wr_data_i;
      else if (hr_inc)                      hr_u_q <= hr_nu;
      if (hit(wr_en_i, wr_addr_i, ADR_HR_T)) hr_t_q <= wr_data_i[1:0];
      else if (hr_inc)                      hr_t_q <= hr_nt;
    end
  end

  // days, weekday, months, years
  logic [5:0] day_last;
  logic day_end, mon_inc, mon_end, yr_inc;
  assign day_last = last_day(mon_t_q, mon_u_q, leap_q == 2'd0);
  assign day_end  = ({day_t_q, day_u_q} == day_last);
  assign mon_inc  = day_inc && day_end;
  assign mon_end  = mon_t_q && (mon_u_q == 4'd2);
  assign yr_inc   = mon_inc && mon_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_u_q <= 4'd1;
      day_t_q <= '0;
      dow_q   <= 3'd1;
      mon_u_q <= 4'd1;
      mon_t_q <= 1'b0;
      yr_u_q  <= '0;
      yr_t_q  <= '0;
    end else begin
      if (hit(wr_en_i, wr_addr_i, ADR_DAY_U)) day_u_q <= wr_data_i;
      else if (day_inc) day_u_q <= day_end ? 4'd1 : (day_u_q == 4'd9 ? 4'd0 : day_u_q + 4'd1);
      if (hit(wr_en_i, wr_addr_i, ADR_DAY_T)) day_t_q <= wr_data_i[1:0];
      else if (day_inc) day_t_q <= day_end ? 2'd0 : (day_u_q == 4'd9 ? day_t_q + 2'd1 : day_t_q);

      if (hit(wr_en_i, wr_addr_i, ADR_DOW)) dow_q <= wr_data_i[2:0];
      else if (day_inc) dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;

      if (hit(wr_en_i, wr_addr_i, ADR_MON_U)) mon_u_q <= wr_data_i;
      else if (mon_inc) mon_u_q <= mon_end ? 4'd1 : (mon_u_q == 4'd9 ? 4'd0 : mon_u_q + 4'd1);
      if (hit(wr_en_i, wr_addr_i, ADR_MON_T)) mon_t_q <= wr_data_i[0];
      else if (mon_inc) mon_t_q <= mon_end ? 1'b0 : (mon_u_q == 4'd9 ? 1'b1 : mon_t_q);

      if (hit(wr_en_i, wr_addr_i, ADR_YR_U)) yr_u_q <= wr_data_i;
      else if (yr_inc) yr_u_q <= (yr_u_q == 4'd9) ? 4'd0 : yr_u_q + 4'd1;
      if (hit(wr_en_i, wr_addr_i, ADR_YR_T)) yr_t_q <= wr_data_i;
      else if (yr_inc && yr_u_q == 4'd9) yr_t_q <= (yr_t_q == 4'd9) ? 4'd0 : yr_t_q + 4'd1;
    end
  end

  // mode: 24h, pm, leap counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h24_q  <= 1'b1;
      pm_q   <= 1'b0;
      leap_q <= 2'd0;
    end else if (hit(wr_en_i, wr_addr_i, ADR_MODE)) begin
      h24_q  <= wr_data_i[0];
      pm_q   <= wr_data_i[1];
      leap_q <= wr_data_i[3:2];
    end else begin
      if (hr_inc && pm_flip) pm_q   <= ~pm_q;
      if (yr_inc)            leap_q <= leap_q + 2'd1;
    end
  end

  always_comb begin
    time_o        = '0;
    time_o.tenths = tenths_q;
    time_o.sec_u  = pair_u[0];
    time_o.sec_t  = pair_t[0];
    time_o.min_u  = pair_u[1];
    time_o.min_t  = pair_t[1];
    time_o.hr_u   = hr_u_q;
    time_o.hr_t   = hr_t_q;
    time_o.day_u  = day_u_q;
    time_o.day_t  = day_t_q;
    time_o.mon_u  = mon_u_q;
    time_o.mon_t  = mon_t_q;
    time_o.yr_u   = yr_u_q;
    time_o.yr_t   = yr_t_q;
    time_o.dow    = dow_q;
    time_o.h24    = h24_q;
    time_o.pm     = pm_q;
    time_o.leap   = leap_q;
  end

  AST_PM_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_inc && !h24_q && hr_t_q == 2'd1 && hr_u_q == 4'd1 && !wr_en_i) |=> (pm_q != $past(pm_q))); // R9
  AST_DOW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_inc && dow_q == 3'd7 && !wr_en_i) |=> (dow_q == 3'd1)); // R12
  AST_LEAP_FEB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_inc && !mon_t_q && mon_u_q == 4'd2 && day_t_q == 2'd2 && day_u_q == 4'd8 && leap_q == 2'd0 && !wr_en_i)
      |=> (day_u_q == 4'd9)); // R11
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [NIB_W-1:0]  rdata_o
);
  localparam int STOP_BIT = 2;
  localparam int DCHG_BIT = 3;

  logic rd_start, wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [NIB_W-1:0]  wr_data;
  logic stop_q, dchg_q, ctrl_wr, clr_tenths, tick_run;
  rtc_time_t t;

  rtc_bus_if #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .rd_ni       (rd_ni),
    .wr_ni       (wr_ni),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rd_start_o  (rd_start),
    .wr_commit_o (wr_commit),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data)
  );

  assign ctrl_wr    = wr_commit && (wr_addr == ADR_CTRL);
  assign clr_tenths = ctrl_wr && wr_data[STOP_BIT];
  assign tick_run   = tick_i && !stop_q;

  rtc_time_core u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_run),
    .clr_tenths_i (clr_tenths),
    .wr_en_i      (wr_commit),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .time_o       (t)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b1;
      dchg_q <= 1'b0;
    end else begin
      if (ctrl_wr) stop_q <= wr_data[STOP_BIT];
      // update wins over read-clear
      if (tick_run)                               dchg_q <= 1'b1;
      else if (rd_start && addr_i == ADR_CTRL)    dchg_q <= 1'b0;
    end
  end

  logic [NIB_W-1:0] rd_mux;
  always_comb begin
    case (addr_i)
      ADR_CTRL:   rd_mux = {dchg_q, stop_q, 2'b00};
      ADR_TENTHS: rd_mux = t.tenths;
      ADR_SEC_U:  rd_mux = t.sec_u;
      ADR_SEC_T:  rd_mux = {1'b0, t.sec_t};
      ADR_MIN_U:  rd_mux = t.min_u;
      ADR_MIN_T:  rd_mux = {1'b0, t.min_t};
      ADR_HR_U:   rd_mux = t.hr_u;
      ADR_HR_T:   rd_mux = {2'b00, t.hr_t};
      ADR_DAY_U:  rd_mux = t.day_u;
      ADR_DAY_T:  rd_mux = {2'b00, t.day_t};
      ADR_MON_U:  rd_mux = t.mon_u;
      ADR_MON_T:  rd_mux = {3'b000, t.mon_t};
      ADR_YR_U:   rd_mux = t.yr_u;
      ADR_YR_T:   rd_mux = t.yr_t;
      ADR_DOW:    rd_mux = {1'b0, t.dow};
      default:    rd_mux = {t.leap, t.pm, t.h24};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (rd_start) rdata_o <= rd_mux;
  end

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_run |=> dchg_q); // R7
  AST_STOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_tenths |=> (t.tenths == 4'd0)); // R4
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !wr_commit) |=> ($stable(t) && $stable(dchg_q) || !dchg_q)); // R4
endmodule

// File: tb/rtc_regbank_tb.sv
module rtc_regbank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0, wdata = '0;
  logic [3:0] rdata;

  int checks = 0;
  int failures = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  event       chk_ev;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  rtc_regbank u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .cs_ni   (cs_n),
    .rd_ni   (rd_n),
    .wr_ni   (wr_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  // monitor: pops expected items and compares with the bus result
  always @(chk_ev) begin
    while (exp_q.size() > 0) begin
      logic [3:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        failures++;
        $display("FAIL %s: got %0d expected %0d", tg, rdata, e);
      end
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [3:0] e, input string tg);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tg);
    -> chk_ev;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // 23:59:59.9 (or 11:59:59.9 when tens/units given)
  task automatic set_eod(input logic [3:0] hu, input logic [3:0] ht);
    bus_wr(4'd1, 4'd9);
    bus_wr(4'd2, 4'd9); bus_wr(4'd3, 4'd5);
    bus_wr(4'd4, 4'd9); bus_wr(4'd5, 4'd5);
    bus_wr(4'd6, hu);   bus_wr(4'd7, ht);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R13 reset state
    bus_rd(4'd0,  4'd4, "R13 ctrl");
    bus_rd(4'd8,  4'd1, "R13 day");
    bus_rd(4'd10, 4'd1, "R13 month");
    bus_rd(4'd14, 4'd1, "R13 dow");
    bus_rd(4'd15, 4'd1, "R13 mode");
    bus_rd(4'd6,  4'd0, "R13 hours");

    // R4 ticks ignored while stopped
    pulse(3);
    bus_rd(4'd1, 4'd0, "R4 tenths stopped");
    bus_rd(4'd0, 4'd4, "R4 no flag while stopped");

    // start, then full rollover Dec 31 99 23:59:59.9
    bus_wr(4'd0, 4'd0);
    bus_rd(4'd0, 4'd0, "R1 ctrl after write");
    bus_wr(4'd15, 4'd13);
    bus_wr(4'd10, 4'd2); bus_wr(4'd11, 4'd1);
    bus_wr(4'd8, 4'd1);  bus_wr(4'd9, 4'd3);
    bus_wr(4'd12, 4'd9); bus_wr(4'd13, 4'd9);
    bus_wr(4'd14, 4'd7);
    set_eod(4'd3, 4'd2);
    bus_rd(4'd13, 4'd9, "R2 year tens readback");
    pulse(1);
    bus_rd(4'd1,  4'd0, "R6 tenths wrap");
    bus_rd(4'd3,  4'd0, "R6 sec tens");
    bus_rd(4'd5,  4'd0, "R6 min tens");
    bus_rd(4'd7,  4'd0, "R8 hour tens");
    bus_rd(4'd6,  4'd0, "R8 hour units");
    bus_rd(4'd8,  4'd1, "R10 day units");
    bus_rd(4'd9,  4'd0, "R10 day tens");
    bus_rd(4'd10, 4'd1, "R10 month units");
    bus_rd(4'd11, 4'd0, "R10 month tens");
    bus_rd(4'd12, 4'd0, "R11 year units");
    bus_rd(4'd13, 4'd0, "R11 year tens");
    bus_rd(4'd15, 4'd1, "R11 leap counter wrap");
    bus_rd(4'd14, 4'd1, "R12 dow wrap");
    bus_rd(4'd0,  4'd8, "R7 flag set");
    bus_rd(4'd0,  4'd0, "R7 flag cleared by read");

    // R11 leap February
    bus_wr(4'd15, 4'd1);
    bus_wr(4'd10, 4'd2); bus_wr(4'd11, 4'd0);
    bus_wr(4'd8, 4'd8);  bus_wr(4'd9, 4'd2);
    set_eod(4'd3, 4'd2);
    pulse(1);
    bus_rd(4'd8,  4'd9, "R11 leap feb 29");
    bus_rd(4'd10, 4'd2, "R11 still feb");
    set_eod(4'd3, 4'd2);
    pulse(1);
    bus_rd(4'd8,  4'd1, "R11 feb 29 ends");
    bus_rd(4'd10, 4'd3, "R11 march");

    // R11 non-leap February
    bus_wr(4'd15, 4'd5);
    bus_wr(4'd10, 4'd2);
    bus_wr(4'd8, 4'd8);  bus_wr(4'd9, 4'd2);
    set_eod(4'd3, 4'd2);
    pulse(1);
    bus_rd(4'd8,  4'd1, "R11 nonleap feb 28 ends");
    bus_rd(4'd10, 4'd3, "R11 nonleap march");
    bus_rd(4'd15, 4'd5, "R11 leap counter kept");

    // R10 30-day month
    bus_wr(4'd10, 4'd4);
    bus_wr(4'd8, 4'd0);  bus_wr(4'd9, 4'd3);
    set_eod(4'd3, 4'd2);
    pulse(1);
    bus_rd(4'd8,  4'd1, "R10 april 30 ends");
    bus_rd(4'd10, 4'd5, "R10 may");

    // R6 partial carry 12:34:59.9
    bus_wr(4'd1, 4'd9); bus_wr(4'd2, 4'd9); bus_wr(4'd3, 4'd5);
    bus_wr(4'd4, 4'd4); bus_wr(4'd5, 4'd3);
    bus_wr(4'd6, 4'd2); bus_wr(4'd7, 4'd1);
    pulse(1);
    bus_rd(4'd4, 4'd5, "R6 minute step");
    bus_rd(4'd5, 4'd3, "R6 minute tens held");
    bus_rd(4'd2, 4'd0, "R6 sec units wrap");
    bus_rd(4'd6, 4'd2, "R6 hour held");

    // R9 12-hour mode, AM 11 -> 12 PM
    bus_wr(4'd15, 4'd0);
    bus_wr(4'd8, 4'd5); bus_wr(4'd9, 4'd1);
    set_eod(4'd1, 4'd1);
    pulse(1);
    bus_rd(4'd6,  4'd2, "R9 noon units");
    bus_rd(4'd7,  4'd1, "R9 noon tens");
    bus_rd(4'd15, 4'd2, "R9 pm set");
    bus_rd(4'd8,  4'd5, "R9 no day step at noon");
    set_eod(4'd2, 4'd1);
    pulse(1);
    bus_rd(4'd6,  4'd1, "R9 12 to 1");
    bus_rd(4'd7,  4'd0, "R9 12 to 1 tens");
    bus_rd(4'd15, 4'd2, "R9 pm kept");
    set_eod(4'd1, 4'd1);
    pulse(1);
    bus_rd(4'd6,  4'd2, "R9 midnight units");
    bus_rd(4'd15, 4'd0, "R9 pm cleared");
    bus_rd(4'd8,  4'd6, "R9 day step at midnight");

    // R4/R5 stop and restart
    bus_rd(4'd0, 4'd8, "R7 flag after ticks");
    bus_wr(4'd1, 4'd5);
    bus_wr(4'd0, 4'd4);
    bus_rd(4'd1, 4'd0, "R4 stop clears tenths");
    bus_wr(4'd2, 4'd0); bus_wr(4'd3, 4'd0);
    pulse(3);
    bus_rd(4'd2, 4'd0, "R4 stopped seconds");
    bus_rd(4'd0, 4'd4, "R4 stopped ctrl");
    bus_wr(4'd0, 4'd0);
    pulse(9);
    bus_rd(4'd2, 4'd0, "R5 nine ticks no second");
    bus_rd(4'd1, 4'd9, "R5 tenths at 9");
    pulse(1);
    bus_rd(4'd2, 4'd1, "R5 whole second");
    bus_rd(4'd1, 4'd0, "R5 tenths zero");

    // R3 unused bits
    bus_wr(4'd14, 4'hF);
    bus_rd(4'd14, 4'd7, "R3 dow width");
    bus_wr(4'd11, 4'hF);
    bus_rd(4'd11, 4'd1, "R3 month tens width");
    bus_wr(4'd3, 4'hF);
    bus_rd(4'd3, 4'd7, "R3 sec tens width");
    bus_wr(4'd9, 4'hF);
    bus_rd(4'd9, 4'd3, "R3 day tens width");
    bus_rd(4'd0, 4'd8, "R7 flag before ctrl write");
    bus_wr(4'd0, 4'hB);
    bus_rd(4'd0, 4'd0, "R4 flag bit write ignored");

    // R7 tick in the same cycle as control read
    @(negedge clk);
    addr = 4'd0; cs_n = 1'b0; rd_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2) @(negedge clk);
    exp_q.push_back(4'd0); tag_q.push_back("R7 captured before update");
    -> chk_ev;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(4'd0, 4'd8, "R7 update beats clear");
    bus_rd(4'd0, 4'd0, "R7 later clear");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule